// File: doc/BRIEF.md
# ADC Selection Shadow Register

This block sits between the software-writable converter selection byte and the analog side of an ADC. Software writes an 8-bit selection holding a 6-bit input channel and a 2-bit reference source. A shadow copy of that byte drives the multiplexer and the reference switches.

While the converter is idle, the shadow copy follows the software byte. A conversion starts on the clock edge after the one that registers the start request. From that edge the shadow is frozen, so the sampled input cannot change under the converter. It is released again in the last clock of the conversion. As a result, in free-running mode a selection written during a conversion takes effect one conversion later.

A small sequencer model is included. It covers start, busy, a one-cycle completion flag, single and free-running operation, abort on disable, and release on leaving free-running mode. It also keeps a sticky flag that marks the first result taken after a reference change as one to throw away.

Top module: `adc_sel_shadow`

## Requirements
- R1: After reset, chanSel and refSel are 0, and busy, convDone and discardFlag are low.
- R2: selWdata[5:0] is the channel and selWdata[7:6] the reference code. When selWe is sampled at an edge while idle, the shadow outputs show the new value after the following edge.
- R3: A conversion begins at the edge after the one that samples startWr while enabled and idle. Busy is then high for exactly 13 cycles, and convDone is high only in the 13th of them.
- R4: A write sampled at the same edge as the start request is used by that conversion. Writes sampled at any later edge are not, and chanSel/refSel hold their value while the conversion is locked.
- R5: The shadow tracks again in the final cycle, so after a single conversion ends it shows the latest write.
- R6: While convDone is high, resultChan/resultRef report the selection the conversion sampled, which is the shadow value at its start.
- R7: With freeRun high, the next conversion begins at the edge that ends the previous one. A write landing at or before the edge that opens a conversion's final cycle is used by the next conversion. A later write is used by the one after that.
- R8: Reference codes are 00 supply, 01 internal 1.1 V, 10 external pin, and 11 reserved. At each completion, discardFlag is set if the reference differs from that of the previous completed conversion (00 after reset), and cleared otherwise. A resultRd pulse clears it, but a completion in the same cycle takes precedence.
- R9: Driving adcEnable low aborts a conversion at the next edge and lets the shadow track at once. A startWr seen while disabled is forgotten.
- R10: A falling freeRun during a conversion releases the lock, so the shadow tracks from the second edge after. That conversion still completes, and no new one follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | converter clock |
| rst_n | input | 1 | active-low reset |
| selWe | input | 1 | write strobe for the software selection byte |
| selWdata | input | 8 | written selection: [7:6] reference, [5:0] channel |
| adcEnable | input | 1 | converter enable |
| freeRun | input | 1 | free-running (auto restart) mode |
| startWr | input | 1 | start request pulse |
| resultRd | input | 1 | result read pulse, clears discardFlag |
| chanSel | output | 6 | shadow channel to the multiplexer |
| refSel | output | 2 | shadow reference to the reference switches |
| busy | output | 1 | conversion in progress |
| convDone | output | 1 | high in the final cycle of a conversion |
| resultChan | output | 6 | channel used by the finishing conversion |
| resultRef | output | 2 | reference used by the finishing conversion |
| discardFlag | output | 1 | sticky: last result followed a reference change |

## Verification
The assertions check four things on every clock:
- the shadow never moves after a locked cycle;
- an idle write reaches the shadow two edges later;
- convDone is a single-cycle pulse inside busy, and disabling clears busy;
- discardFlag only rises at a completion.

Which conversion a given write lands in depends on where the write falls relative to the start, so only the bench's scenarios can show it. The bench sweeps the write offset across single and free-running conversions. It also covers the discard sequence across reference changes and reads, and the abort and mode-exit releases.

// File: rtl/adc_sel_pkg.sv
package adc_sel_pkg;
  localparam int CHAN_W = 6;
  localparam int REF_W  = 2;
  localparam int SEL_W  = CHAN_W + REF_W;

  // reference in the upper bits, channel in the lower bits (R2)
  typedef struct packed {
    logic [REF_W-1:0]  refCode;
    logic [CHAN_W-1:0] chan;
  } selT;

  // strobes from the sequencer to the selection datapath
  typedef struct packed {
    logic track;     // shadow may load the software byte at this edge
    logic sample;    // capture the shadow as the conversion's selection
    logic complete;  // final cycle: conversion ends at this edge
  } seqStbT;
endpackage

// File: rtl/adc_sel_ctrl.sv
module adc_sel_ctrl
  import adc_sel_pkg::*;
#(
  parameter int CONV_CYCLES = 13,
  parameter int SAMPLE_CYC  = 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   adcEnable,
  input  logic   freeRun,
  input  logic   startWr,
  output logic   busy,
  output logic   convDone,
  output seqStbT seqStb
);
  localparam int CNT_W = $clog2(CONV_CYCLES);
  localparam logic [CNT_W-1:0] LAST_C   = CNT_W'(CONV_CYCLES - 1);
  localparam logic [CNT_W-1:0] SAMPLE_C = CNT_W'(SAMPLE_CYC);

  logic             busyQ;
  logic [CNT_W-1:0] cntQ;
  logic             startReqQ;
  logic             autoPrevQ;
  logic             releaseQ;

  logic lastCyc, autoFall, lockNow, beginConv;

  assign lastCyc   = busyQ && (cntQ == LAST_C);
  assign autoFall  = autoPrevQ && !freeRun;
  // R4/R5/R9: frozen while converting, except final cycle, abort or mode exit
  assign lockNow   = busyQ && adcEnable && !lastCyc && !releaseQ;
  // R3 start from request, R7 automatic restart
  assign beginConv = adcEnable && ((startReqQ && !busyQ) || (lastCyc && freeRun));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyQ     <= 1'b0;
      cntQ      <= '0;
      startReqQ <= 1'b0;
      autoPrevQ <= 1'b0;
      releaseQ  <= 1'b0;
    end else begin
      autoPrevQ <= freeRun;
      if (!adcEnable) begin
        // R9: abort and forget any pending request
        busyQ     <= 1'b0;
        cntQ      <= '0;
        startReqQ <= 1'b0;
        releaseQ  <= 1'b0;
      end else if (beginConv) begin
        busyQ     <= 1'b1;
        cntQ      <= '0;
        startReqQ <= 1'b0;
        releaseQ  <= 1'b0;
      end else begin
        if (startWr && !busyQ) startReqQ <= 1'b1;
        if (lastCyc) begin
          busyQ <= 1'b0;
          cntQ  <= '0;
        end else if (busyQ) begin
          cntQ <= cntQ + 1'b1;
          if (autoFall) releaseQ <= 1'b1;  // R10
        end
      end
    end
  end

  assign busy            = busyQ;
  assign convDone        = lastCyc && adcEnable;
  assign seqStb.track    = !lockNow;
  assign seqStb.sample   = busyQ && adcEnable && (cntQ == SAMPLE_C);
  assign seqStb.complete = lastCyc && adcEnable;
endmodule

// File: rtl/adc_sel_dp.sv
module adc_sel_dp
  import adc_sel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             selWe,
  input  logic [SEL_W-1:0] selWdata,
  input  logic             resultRd,
  input  seqStbT           seqStb,
  output selT              shadowSel,
  output selT              resultSel,
  output logic             discardFlag
);
  selT              cpuSelQ;
  selT              shadowQ;
  selT              resultQ;
  logic [REF_W-1:0] prevRefQ;
  logic             discardQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpuSelQ  <= '0;
      shadowQ  <= '0;
      resultQ  <= '0;
      prevRefQ <= '0;
      discardQ <= 1'b0;
    end else begin
      if (selWe) cpuSelQ <= selT'(selWdata);
      if (seqStb.track) shadowQ <= cpuSelQ;      // R2/R5
      if (seqStb.sample) resultQ <= shadowQ;     // R6
      if (seqStb.complete) begin                 // R8: completion wins over read
        prevRefQ <= resultQ.refCode;
        discardQ <= (resultQ.refCode != prevRefQ);
      end else if (resultRd) begin
        discardQ <= 1'b0;
      end
    end
  end

  assign shadowSel   = shadowQ;
  assign resultSel   = resultQ;
  assign discardFlag = discardQ;
endmodule

// File: rtl/adc_sel_shadow.sv
module adc_sel_shadow
  import adc_sel_pkg::*;
#(
  parameter int CONV_CYCLES = 13,
  parameter int SAMPLE_CYC  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              selWe,
  input  logic [SEL_W-1:0]  selWdata,
  input  logic              adcEnable,
  input  logic              freeRun,
  input  logic              startWr,
  input  logic              resultRd,
  output logic [CHAN_W-1:0] chanSel,
  output logic [REF_W-1:0]  refSel,
  output logic              busy,
  output logic              convDone,
  output logic [CHAN_W-1:0] resultChan,
  output logic [REF_W-1:0]  resultRef,
  output logic              discardFlag
);
  seqStbT seqStb;
  selT    shadowSel;
  selT    resultSel;

  adc_sel_ctrl #(.CONV_CYCLES(CONV_CYCLES), .SAMPLE_CYC(SAMPLE_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .adcEnable(adcEnable), .freeRun(freeRun),
    .startWr(startWr), .busy(busy), .convDone(convDone), .seqStb(seqStb)
  );

  adc_sel_dp u_dp (
    .clk(clk), .rst_n(rst_n), .selWe(selWe), .selWdata(selWdata),
    .resultRd(resultRd), .seqStb(seqStb), .shadowSel(shadowSel),
    .resultSel(resultSel), .discardFlag(discardFlag)
  );

  assign chanSel    = shadowSel.chan;
  assign refSel     = shadowSel.refCode;
  assign resultChan = resultSel.chan;
  assign resultRef  = resultSel.refCode;
endmodule

// File: rtl/adc_sel_shadow_chk.sv
module adc_sel_shadow_chk
  import adc_sel_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              selWe,
  input logic [SEL_W-1:0]  selWdata,
  input logic              adcEnable,
  input logic [CHAN_W-1:0] chanSel,
  input logic [REF_W-1:0]  refSel,
  input logic              busy,
  input logic              convDone,
  input logic              discardFlag,
  input seqStbT            seqStb
);
  a_r4_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!seqStb.track) |-> $stable({refSel, chanSel}));

  a_r2_idle_follow: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(selWe, 2) && $past(seqStb.track) && $past(seqStb.track, 2))
      |-> ({refSel, chanSel} == $past(selWdata, 2)));

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    convDone |=> !convDone);

  a_r3_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    convDone |-> busy);

  a_r9_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !adcEnable |=> !busy);

  a_r8_discard_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(discardFlag) |-> $past(convDone));
endmodule

bind adc_sel_shadow adc_sel_shadow_chk u_chk (
  .clk(clk), .rst_n(rst_n), .selWe(selWe), .selWdata(selWdata),
  .adcEnable(adcEnable), .chanSel(chanSel), .refSel(refSel), .busy(busy),
  .convDone(convDone), .discardFlag(discardFlag), .seqStb(seqStb)
);

// File: tb/sim_adc_sel_shadow.sv
module sim_adc_sel_shadow;
  logic clk = 1'b0;
  logic rst_n, selWe, adcEnable, freeRun, startWr, resultRd;
  logic [7:0] selWdata;
  logic [5:0] chanSel, resultChan;
  logic [1:0] refSel, resultRef;
  logic busy, convDone, discardFlag;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  adc_sel_shadow u0 (
    .clk(clk), .rst_n(rst_n), .selWe(selWe), .selWdata(selWdata),
    .adcEnable(adcEnable), .freeRun(freeRun), .startWr(startWr),
    .resultRd(resultRd), .chanSel(chanSel), .refSel(refSel), .busy(busy),
    .convDone(convDone), .resultChan(resultChan), .resultRef(resultRef),
    .discardFlag(discardFlag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeSel(input logic [7:0] v);
    selWe = 1'b1; selWdata = v; tick(); selWe = 1'b0;
  endtask

  // one single conversion; returns its selection, ends after the completion edge
  task automatic runSingle(input logic [7:0] v, output int rc, output int rr);
    writeSel(v); tick();
    startWr = 1'b1; tick(); startWr = 1'b0;
    rc = -1; rr = -1;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (convDone) begin rc = resultChan; rr = resultRef; break; end
    end
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R3 watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int rc, rr, n, exp0, exp1;
    int res[3];
    rst_n = 0; selWe = 0; selWdata = 0; adcEnable = 0; freeRun = 0;
    startWr = 0; resultRd = 0;
    repeat (3) tick();
    rst_n = 1; tick();

    // R1 reset state
    chk("R1 chanSel", chanSel, 0);
    chk("R1 refSel", refSel, 0);
    chk("R1 busy", busy, 0);
    chk("R1 convDone", convDone, 0);
    chk("R1 discardFlag", discardFlag, 0);

    adcEnable = 1;
    // R2 idle tracking and field layout
    selWe = 1; selWdata = 8'b10_010101; tick(); selWe = 0;
    chk("R2 not yet", chanSel, 0);
    tick();
    chk("R2 chan", chanSel, 21);
    chk("R2 ref", refSel, 2);

    // single-mode sweep of write offset against the start request
    for (int k = 0; k <= 15; k++) begin
      writeSel(8'd5); repeat (3) tick();
      for (int c = 0; c <= 16; c++) begin
        startWr = (c == 0); selWe = (c == k); selWdata = 8'(40 + k);
        tick();
        exp0 = (k == 0) ? 40 + k : 5;
        if (c == 0)  chk("R3 not started", busy, 0);
        if (c == 1)  chk("R3 busy", busy, 1);
        if (c == 5)  chk("R4 frozen", chanSel, exp0);
        if (c == 12) chk("R3 no early done", convDone, 0);
        if (c == 13) begin
          chk("R3 done", convDone, 1);
          chk("R6 result chan", resultChan, exp0);
        end
        if (c == 14) chk("R3 idle after", busy, 0);
        if (c == 16) chk("R5 released", chanSel, 40 + k);
      end
      startWr = 0; selWe = 0;
    end

    // free-running sweep
    for (int k = 0; k <= 20; k++) begin
      freeRun = 1; adcEnable = 1;
      writeSel(8'd6); repeat (3) tick();
      n = 0;
      for (int c = 0; c <= 40; c++) begin
        startWr = (c == 0); selWe = (c == k); selWdata = 8'(50 + (k % 10));
        tick();
        if (convDone) begin
          if (n < 3) begin
            chk("R7 done cycle", c, 13 + 13 * n);
            res[n] = resultChan;
          end
          n++;
        end
      end
      startWr = 0; selWe = 0;
      chk("R7 count", n, 3);
      exp0 = (k == 0) ? 50 + (k % 10) : 6;
      exp1 = (k <= 13) ? 50 + (k % 10) : 6;
      chk("R7 first", res[0], exp0);
      chk("R7 second", res[1], exp1);
      chk("R7 third", res[2], 50 + (k % 10));
      adcEnable = 0; freeRun = 0; tick(); tick();
      chk("R9 aborted", busy, 0);
      adcEnable = 1;
    end

    // R8 discard flag
    runSingle(8'b00_000011, rc, rr);
    chk("R6 single chan", rc, 3);
    chk("R8 same ref", discardFlag, 0);
    runSingle(8'b01_000011, rc, rr);
    chk("R8 result ref", rr, 1);
    chk("R8 ref changed", discardFlag, 1);
    resultRd = 1; tick(); resultRd = 0;
    chk("R8 read clears", discardFlag, 0);
    runSingle(8'b01_000100, rc, rr);
    chk("R8 unchanged", discardFlag, 0);
    runSingle(8'b10_000100, rc, rr);
    chk("R8 changed again", discardFlag, 1);
    runSingle(8'b10_000100, rc, rr);
    chk("R8 next completion clears", discardFlag, 0);
    // completion wins over read in the same cycle
    writeSel(8'b00_000001); tick();
    startWr = 1; tick(); startWr = 0;
    for (int i = 0; i < 20; i++) begin
      if (convDone) break;
      tick();
    end
    resultRd = 1; tick(); resultRd = 0;
    chk("R8 completion priority", discardFlag, 1);

    // R9 abort and forgotten start
    writeSel(8'd9); tick();
    startWr = 1; tick(); startWr = 0;
    repeat (4) tick();
    chk("R9 running", busy, 1);
    adcEnable = 0; selWe = 1; selWdata = 8'd60; tick(); selWe = 0;
    chk("R9 stopped", busy, 0);
    tick();
    chk("R9 tracks", chanSel, 60);
    startWr = 1; tick(); startWr = 0; tick();
    adcEnable = 1; repeat (3) tick();
    chk("R9 start forgotten", busy, 0);

    // R10 leaving free-running mode releases the lock
    freeRun = 1;
    writeSel(8'd7); tick();
    startWr = 1; tick(); startWr = 0;
    repeat (3) tick();
    writeSel(8'd33); tick();
    chk("R4 held in run", chanSel, 7);
    freeRun = 0; tick(); tick();
    chk("R10 released", chanSel, 33);
    chk("R10 still busy", busy, 1);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (convDone) n++;
    end
    chk("R10 one completion", n, 1);
    chk("R10 no restart", busy, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule